// File: doc/BRIEF.md
# Ethernet Receive Ping-Pong Buffer with Destination Filter

This block sits behind the receive side of an Ethernet MAC. Bytes of an incoming frame arrive one per cycle with a last flag. The block screens each frame on its destination address and writes the bytes into one of two receive buffers. When a frame has been stored completely, it sets that buffer's full flag. Software on a simple word-wide register bus reads the frame out of the buffer. It then clears the full flag to hand the buffer back.

In ping-pong mode the two buffers take turns, so one buffer can be drained while the other fills. With ping-pong off, every frame goes to buffer 0. The block drops a frame when the target buffer is still full, when the frame is too long for the buffer, or when its destination is neither the station address nor a group address. A dropped frame leaves the full flag clear, so software never sees partial data. A one-cycle interrupt pulse can mark each stored frame.

Top module: `eth_rxpp_top`

## Requirements
- R1: After reset, buffer 0 is the active buffer, both full flags, both interrupt-enable bits and the global enable are clear, and `rx_irq` is low.
- R2: Byte k of a stored frame lands in word k/4 of its buffer, in bits 8*(k%4)+7 down to 8*(k%4). Buffer b starts at byte address 0x1000 + 0x800*b. A read returns its data on `bus_rdata` the cycle after `bus_rd` is sampled.
- R3: A frame is kept only in two cases: bit 7 of its first byte is set, or bytes 0..5 equal `station_addr[47:40]` through `station_addr[7:0]` in that order. A rejected frame leaves the full flag clear, raises no interrupt and does not change the active buffer.
- R4: If the active buffer's full flag is set when a frame's first byte arrives, the whole frame is dropped. The buffer's contents and flags stay unchanged, there is no interrupt, and the active buffer stays the same.
- R5: A frame longer than 2044 bytes (the buffer less its control word) is dropped, and so is a frame shorter than 6 bytes. Either way the full flag stays clear and there is no interrupt.
- R6: The full flag of the frame's buffer reads 1 once the last byte of a kept frame has been taken. The full flag is bit 0 of the control word at buffer offset 0x7FC.
- R7: A kept frame produces a one-cycle `rx_irq` pulse in the cycle after its last byte, but only when two bits are set: interrupt-enable bit 3 of buffer 0's control word (0x17FC), and global enable bit 31 of the word at 0x07F8.
- R8: With `pp_en` high, the active buffer alternates after each kept frame. With `pp_en` low, every frame uses buffer 0.
- R9: A bus write to a control word loads the full flag from data bit 0 and the interrupt enable from bit 3, so writing bit 0 as 0 releases the buffer. A control word reads back full at bit 0 and enable at bit 3, with every other bit 0. The global enable word reads back bit 31 alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pp_en | input | 1 | Ping-pong mode enable |
| station_addr | input | 48 | Station address, first byte in bits 47:40 |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_last | input | 1 | Marks the final byte of a frame |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 13 | Byte address of a 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| rx_irq | output | 1 | One-cycle frame-stored pulse |

## Verification
The checker assumes that software never writes a control word while a frame bound for that buffer is arriving. It also assumes that bus addresses are word aligned and that a frame's bytes are not interrupted by a reset. Under these conditions, a buffer whose flag was clear at a frame's start is still clear while that frame writes into it. The stimulus touches control words only between frames and only at aligned addresses. It does keep driving bytes into buffers that are full, too short or too long, since those are the drop conditions under test.

// File: rtl/eth_rxpp_pkg.sv
package eth_rxpp_pkg;
   localparam int unsigned NUM_BUFS  = 2;
   localparam int unsigned MAC_BYTES = 6;
   localparam int unsigned LANES     = 4;
   localparam int unsigned FULL_BIT  = 0;
   localparam int unsigned IEN_BIT   = 3;
   localparam int unsigned GEN_BIT   = 31;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_GEN  = 2'd1,
      RK_DATA = 2'd2,
      RK_CTRL = 2'd3
   } reg_kind_e;
endpackage

// File: rtl/eth_rxpp_addr_filter.sv
module eth_rxpp_addr_filter
   import eth_rxpp_pkg::*;
#(
   parameter int unsigned IW = 11
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          beat_valid,
   input  logic          beat_first,
   input  logic [IW-1:0] idx,
   input  logic [7:0]    data,
   input  logic [47:0]   station,
   output logic          pass_now,
   output logic          fail_known
);
   localparam logic [IW-1:0] LAST_DA = IW'(MAC_BYTES - 1);

   logic       grp_q, eq_q;
   logic       grp_cur, eq_cur, in_da;
   logic [7:0] want;

   always_comb begin
      want = 8'h00;
      for (int i = 0; i < int'(MAC_BYTES); i++) begin
         if (idx == IW'(i)) want = station[8*(int'(MAC_BYTES)-1-i) +: 8];
      end
   end

   assign in_da   = (idx <= LAST_DA);
   assign grp_cur = beat_first ? data[7] : grp_q;
   assign eq_cur  = (beat_first ? 1'b1 : eq_q) & (in_da ? (data == want) : 1'b1);

   assign pass_now   = (idx >= LAST_DA) && (grp_cur || eq_cur);
   assign fail_known = (idx >= LAST_DA) && !(grp_cur || eq_cur);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q <= 1'b0;
         eq_q  <= 1'b0;
      end else if (beat_valid) begin
         grp_q <= grp_cur;
         eq_q  <= eq_cur;
      end
   end
endmodule

// File: rtl/eth_rxpp_frame.sv
module eth_rxpp_frame
   import eth_rxpp_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 2048,
   localparam int unsigned CW  = $clog2(BUF_BYTES),
   localparam int unsigned WW  = CW - 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_valid,
   input  logic                rx_last,
   input  logic                active_buf,
   input  logic [NUM_BUFS-1:0] full,
   input  logic                pass_now,
   input  logic                fail_known,
   output logic                first,
   output logic [CW-1:0]       idx,
   output logic                mem_we,
   output logic                mem_buf,
   output logic [WW-1:0]       mem_word,
   output logic [1:0]          mem_lane,
   output logic                commit,
   output logic                commit_buf
);
   localparam logic [CW-1:0] CAP = CW'(BUF_BYTES - 4);

   logic          in_frame_q, buf_q, blk_q, ovf_q;
   logic [CW-1:0] cnt_q;
   logic          cur_buf, cur_blk, cur_ovf;

   assign first   = rx_valid && !in_frame_q;
   assign cur_buf = first ? active_buf : buf_q;
   assign cur_blk = first ? full[active_buf] : blk_q;
   assign idx     = first ? '0 : cnt_q;
   assign cur_ovf = (first ? 1'b0 : ovf_q) | (idx >= CAP);

   assign mem_we     = rx_valid && !cur_blk && !cur_ovf && !fail_known;
   assign mem_buf    = cur_buf;
   assign mem_word   = idx[CW-1:2];
   assign mem_lane   = idx[1:0];
   assign commit     = rx_valid && rx_last && !cur_blk && !cur_ovf && pass_now;
   assign commit_buf = cur_buf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         buf_q      <= 1'b0;
         blk_q      <= 1'b0;
         ovf_q      <= 1'b0;
         cnt_q      <= '0;
      end else if (rx_valid) begin
         in_frame_q <= !rx_last;
         buf_q      <= cur_buf;
         blk_q      <= cur_blk;
         ovf_q      <= cur_ovf;
         cnt_q      <= (idx >= CAP) ? CAP : idx + 1'b1;
      end
   end
endmodule

// File: rtl/eth_rxpp_bufmem.sv
module eth_rxpp_bufmem
   import eth_rxpp_pkg::*;
#(
   parameter int unsigned WORDS = 512,
   localparam int unsigned WW    = $clog2(WORDS),
   localparam int unsigned DEPTH = NUM_BUFS * WORDS,
   localparam int unsigned DW    = 8 * LANES
) (
   input  logic          clk,
   input  logic          we,
   input  logic          wbuf,
   input  logic [WW-1:0] wword,
   input  logic [1:0]    wlane,
   input  logic [7:0]    wbyte,
   input  logic          re,
   input  logic          rbuf,
   input  logic [WW-1:0] rword,
   output logic [DW-1:0] rdata
);
   logic [WW:0] waddr, raddr;
   assign waddr = {wbuf, wword};
   assign raddr = {rbuf, rword};

   for (genvar l = 0; l < int'(LANES); l++) begin : g_lane
      logic [7:0] store [DEPTH];
      logic [7:0] q;
      always_ff @(posedge clk) begin
         if (we && (wlane == 2'(l))) store[waddr] <= wbyte;
         if (re) q <= store[raddr];
      end
      assign rdata[8*l +: 8] = q;
   end
endmodule

// File: rtl/eth_rxpp_status.sv
module eth_rxpp_status
   import eth_rxpp_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pp_en,
   input  logic                commit,
   input  logic                commit_buf,
   input  logic [NUM_BUFS-1:0] wr_ctrl,
   input  logic                wr_gen,
   input  logic                wd_full,
   input  logic                wd_ien,
   input  logic                wd_gen,
   output logic                active_buf,
   output logic [NUM_BUFS-1:0] full,
   output logic [NUM_BUFS-1:0] ien,
   output logic                gen_en,
   output logic                irq
);
   logic sel_q, irq_q;

   for (genvar b = 0; b < int'(NUM_BUFS); b++) begin : g_buf
      logic hw_set;
      assign hw_set = commit && (commit_buf == 1'(b));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            full[b] <= 1'b0;
            ien[b]  <= 1'b0;
         end else begin
            full[b] <= (wr_ctrl[b] ? wd_full : full[b]) | hw_set;
            if (wr_ctrl[b]) ien[b] <= wd_ien;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q  <= 1'b0;
         gen_en <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (commit) sel_q <= pp_en ? ~commit_buf : 1'b0;
         if (wr_gen) gen_en <= wd_gen;
         irq_q <= commit && ien[0] && gen_en;
      end
   end

   assign active_buf = pp_en & sel_q;
   assign irq        = irq_q;
endmodule

// File: rtl/eth_rxpp_top.sv
module eth_rxpp_top
   import eth_rxpp_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 2048,
   localparam int unsigned ADDR_W = $clog2(4 * BUF_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pp_en,
   input  logic [47:0]       station_addr,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_last,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              rx_irq
);
   localparam int unsigned WORDS  = BUF_BYTES / LANES;
   localparam int unsigned CW     = $clog2(BUF_BYTES);
   localparam int unsigned WORD_W = CW - 2;
   localparam logic [ADDR_W-1:0] GEN_ADDR = ADDR_W'(BUF_BYTES - 8);

   if (BUF_BYTES < 64 || (BUF_BYTES & (BUF_BYTES - 1)) != 0) begin : g_bad_size
      $error("BUF_BYTES must be a power of two of at least 64");
   end

   logic                active_buf, gen_en;
   logic [NUM_BUFS-1:0] full, ien;
   logic                first, pass_now, fail_known;
   logic [CW-1:0]       idx;
   logic                mem_we, mem_buf, commit, commit_buf;
   logic [WORD_W-1:0]   mem_word;
   logic [1:0]          mem_lane;
   logic [31:0]         mem_rd;

   reg_kind_e           acc_kind;
   logic                acc_buf;
   logic [WORD_W-1:0]   acc_word;
   logic [NUM_BUFS-1:0] wr_ctrl;
   logic                wr_gen;
   logic                rd_is_mem_q;
   logic [31:0]         rd_reg_q;
   logic                unused_wdata_bits;

   assign unused_wdata_bits = ^{bus_wdata[30:4], bus_wdata[2:1]};

   assign acc_buf  = bus_addr[ADDR_W-2];
   assign acc_word = bus_addr[ADDR_W-3:2];

   always_comb begin
      if (bus_addr[ADDR_W-1])
         acc_kind = (acc_word == '1) ? RK_CTRL : RK_DATA;
      else if (bus_addr == GEN_ADDR)
         acc_kind = RK_GEN;
      else
         acc_kind = RK_NONE;
   end

   for (genvar b = 0; b < int'(NUM_BUFS); b++) begin : g_wdec
      assign wr_ctrl[b] = bus_wr && (acc_kind == RK_CTRL) && (acc_buf == 1'(b));
   end
   assign wr_gen = bus_wr && (acc_kind == RK_GEN);

   eth_rxpp_addr_filter #(.IW(CW)) u_filter (
      .clk        (clk),
      .rst_n      (rst_n),
      .beat_valid (rx_valid),
      .beat_first (first),
      .idx        (idx),
      .data       (rx_data),
      .station    (station_addr),
      .pass_now   (pass_now),
      .fail_known (fail_known)
   );

   eth_rxpp_frame #(.BUF_BYTES(BUF_BYTES)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_last    (rx_last),
      .active_buf (active_buf),
      .full       (full),
      .pass_now   (pass_now),
      .fail_known (fail_known),
      .first      (first),
      .idx        (idx),
      .mem_we     (mem_we),
      .mem_buf    (mem_buf),
      .mem_word   (mem_word),
      .mem_lane   (mem_lane),
      .commit     (commit),
      .commit_buf (commit_buf)
   );

   eth_rxpp_bufmem #(.WORDS(WORDS)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .wbuf  (mem_buf),
      .wword (mem_word),
      .wlane (mem_lane),
      .wbyte (rx_data),
      .re    (bus_rd),
      .rbuf  (acc_buf),
      .rword (acc_word),
      .rdata (mem_rd)
   );

   eth_rxpp_status u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .pp_en      (pp_en),
      .commit     (commit),
      .commit_buf (commit_buf),
      .wr_ctrl    (wr_ctrl),
      .wr_gen     (wr_gen),
      .wd_full    (bus_wdata[FULL_BIT]),
      .wd_ien     (bus_wdata[IEN_BIT]),
      .wd_gen     (bus_wdata[GEN_BIT]),
      .active_buf (active_buf),
      .full       (full),
      .ien        (ien),
      .gen_en     (gen_en),
      .irq        (rx_irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_is_mem_q <= 1'b0;
         rd_reg_q    <= '0;
      end else if (bus_rd) begin
         rd_is_mem_q <= (acc_kind == RK_DATA);
         rd_reg_q    <= '0;
         unique case (acc_kind)
            RK_CTRL: begin
               rd_reg_q[FULL_BIT] <= full[acc_buf];
               rd_reg_q[IEN_BIT]  <= ien[acc_buf];
            end
            RK_GEN:  rd_reg_q[GEN_BIT] <= gen_en;
            default: ;
         endcase
      end
   end

   assign bus_rdata = rd_is_mem_q ? mem_rd : rd_reg_q;
endmodule

// File: rtl/eth_rxpp_chk.sv
module eth_rxpp_chk #(
   parameter int unsigned WW = 9
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic          rx_last,
   input logic          bus_wr,
   input logic          rx_irq,
   input logic [1:0]    full,
   input logic          mem_we,
   input logic          mem_buf,
   input logic [WW-1:0] mem_word
);
   a_r7_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);

   a_r7_irq_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> $past(rx_valid && rx_last));

   a_r6_full0_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full[0]) |-> ($past(rx_valid && rx_last) || $past(bus_wr)));

   a_r6_full1_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full[1]) |-> ($past(rx_valid && rx_last) || $past(bus_wr)));

   a_r4_no_write_full: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> !full[mem_buf]);

   a_r5_ctrl_word_kept: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (mem_word != '1));
endmodule

bind eth_rxpp_top eth_rxpp_chk #(.WW(WORD_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rx_valid (rx_valid),
   .rx_last  (rx_last),
   .bus_wr   (bus_wr),
   .rx_irq   (rx_irq),
   .full     (full),
   .mem_we   (mem_we),
   .mem_buf  (mem_buf),
   .mem_word (mem_word)
);

// File: tb/eth_rxpp_top_tb_top.sv
module eth_rxpp_top_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [47:0] STA   = 48'h02_11_22_33_44_55;
   localparam logic [47:0] MISS  = 48'h02_11_22_33_44_56;
   localparam logic [47:0] MCAST = 48'h81_00_5E_00_00_01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pp_en = 1'b1;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        rx_last = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [12:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_irq;

   int n_cmp = 0;
   int n_bad = 0;
   logic [31:0] exp_q [$];
   string       tag_q [$];
   logic        rd_d = 1'b0;
   bit          done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eth_rxpp_top dut_i (
      .clk (clk), .rst_n (rst_n), .pp_en (pp_en), .station_addr (STA),
      .rx_valid (rx_valid), .rx_data (rx_data), .rx_last (rx_last),
      .bus_wr (bus_wr), .bus_rd (bus_rd), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .rx_irq (rx_irq)
   );

   function automatic logic [7:0] fbyte(logic [47:0] d, int seed, int k);
      if (k < 6) return d[8*(5-k) +: 8];
      return 8'((seed*13 + k*7 + (k >> 8)) & 255);
   endfunction

   function automatic logic [31:0] fword(logic [47:0] d, int seed, int w);
      return {fbyte(d, seed, 4*w+3), fbyte(d, seed, 4*w+2),
              fbyte(d, seed, 4*w+1), fbyte(d, seed, 4*w)};
   endfunction

   function automatic logic [12:0] dat_addr(int b, int w);
      return 13'(32'h1000 + b*32'h800 + 4*w);
   endfunction

   function automatic logic [12:0] ctl_addr(int b);
      return 13'(32'h17FC + b*32'h800);
   endfunction

   // monitor: pops the scoreboard one cycle after each sampled read
   always @(posedge clk) rd_d <= bus_rd && rst_n;

   always @(negedge clk) begin
      if (rd_d) begin
         n_cmp++;
         if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected read data: got %h expected none", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               n_bad++;
               $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic expect_rd(logic [12:0] a, logic [31:0] e, string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic bus_write(logic [12:0] a, logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic check_bit(logic got, logic e, string t);
      n_cmp++;
      if (got !== e) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b", t, got, e);
      end
   endtask

   task automatic send_frame(logic [47:0] d, int seed, int len, logic irq_e, string t);
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = fbyte(d, seed, k); rx_last = (k == len - 1);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_last = 1'b0;
      check_bit(rx_irq, irq_e, {t, " irq pulse"});
      @(negedge clk);
      check_bit(rx_irq, 1'b0, {t, " irq ends after one cycle"});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired (R1..R9 incomplete): got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check_bit(rx_irq, 1'b0, "R1 irq low after reset");
      expect_rd(ctl_addr(0), 32'h0, "R1 ctrl0 after reset");
      expect_rd(ctl_addr(1), 32'h0, "R1 ctrl1 after reset");
      expect_rd(13'h07F8, 32'h0, "R1 global enable after reset");

      // R9 register set-up and readback
      bus_write(13'h07F8, 32'hFFFF_FFFF);
      bus_write(ctl_addr(0), 32'h0000_0008);
      expect_rd(13'h07F8, 32'h8000_0000, "R9 global enable readback");
      expect_rd(ctl_addr(0), 32'h0000_0008, "R9 ctrl0 enable readback");

      // R3 unicast match, R2 packing, R6, R7
      send_frame(STA, 1, 64, 1'b1, "R7 unicast frame A");
      expect_rd(ctl_addr(0), 32'h9, "R6 ctrl0 full after A");
      expect_rd(dat_addr(0, 0), fword(STA, 1, 0), "R2 A word0");
      expect_rd(dat_addr(0, 1), fword(STA, 1, 1), "R2 A word1");
      expect_rd(dat_addr(0, 15), fword(STA, 1, 15), "R2 A word15");
      expect_rd(ctl_addr(1), 32'h0, "R8 ctrl1 still empty after A");

      // R3 group address, R8 alternation to buffer 1
      send_frame(MCAST, 2, 100, 1'b1, "R3 group frame B");
      expect_rd(ctl_addr(1), 32'h1, "R8 ctrl1 full after B");
      expect_rd(dat_addr(1, 0), fword(MCAST, 2, 0), "R8 B word0 in buffer1");
      expect_rd(dat_addr(1, 24), fword(MCAST, 2, 24), "R2 B last word");

      // R9 release buffer 0
      bus_write(ctl_addr(0), 32'h0000_0008);
      expect_rd(ctl_addr(0), 32'h8, "R9 ctrl0 released");

      // R3 mismatch rejected, active buffer unchanged
      send_frame(MISS, 9, 64, 1'b0, "R3 mismatched frame C");
      expect_rd(ctl_addr(0), 32'h8, "R3 ctrl0 clear after C");
      send_frame(STA, 3, 40, 1'b1, "R3 frame D after rejection");
      expect_rd(ctl_addr(0), 32'h9, "R3 D lands in buffer0");
      expect_rd(dat_addr(0, 2), fword(STA, 3, 2), "R3 D word2 in buffer0");

      // R4 active buffer 1 still full
      send_frame(STA, 4, 32, 1'b0, "R4 blocked frame E");
      expect_rd(ctl_addr(1), 32'h1, "R4 ctrl1 unchanged");
      expect_rd(dat_addr(1, 2), fword(MCAST, 2, 2), "R4 buffer1 data kept");
      expect_rd(dat_addr(1, 7), fword(MCAST, 2, 7), "R4 buffer1 data kept deep");

      // R5 oversize then exact fit
      bus_write(ctl_addr(1), 32'h0);
      send_frame(MCAST, 5, 2045, 1'b0, "R5 oversize frame F");
      expect_rd(ctl_addr(1), 32'h0, "R5 ctrl1 clear after F");
      send_frame(MCAST, 6, 2044, 1'b1, "R5 full-size frame G");
      expect_rd(ctl_addr(1), 32'h1, "R5 ctrl1 full after G");
      expect_rd(dat_addr(1, 510), fword(MCAST, 6, 510), "R5 G last word");
      expect_rd(dat_addr(1, 300), fword(MCAST, 6, 300), "R2 G word300");

      // R5 runt frame
      bus_write(ctl_addr(0), 32'h0000_0008);
      send_frame(MCAST, 7, 5, 1'b0, "R5 runt frame");
      expect_rd(ctl_addr(0), 32'h8, "R5 ctrl0 clear after runt");

      // R7 global enable off, R8 ping-pong off
      bus_write(13'h07F8, 32'h0);
      expect_rd(13'h07F8, 32'h0, "R9 global enable cleared");
      bus_write(ctl_addr(1), 32'h0);
      @(negedge clk);
      pp_en = 1'b0;
      send_frame(STA, 7, 20, 1'b0, "R7 frame H with global enable off");
      expect_rd(ctl_addr(0), 32'h9, "R8 H in buffer0");
      bus_write(ctl_addr(0), 32'h0000_0008);
      send_frame(STA, 8, 24, 1'b0, "R8 frame I");
      expect_rd(ctl_addr(0), 32'h9, "R8 I in buffer0 again");
      expect_rd(ctl_addr(1), 32'h0, "R8 buffer1 untouched with ping-pong off");
      expect_rd(dat_addr(0, 3), fword(STA, 8, 3), "R8 I word3");

      repeat (3) @(negedge clk);
      n_cmp++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R2 scoreboard drain: got %0d left expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule